// File: doc/BRIEF.md
# Weighted Round Queue Scheduler

This block decides which of several transmit queues feeding one output port sends its next packet. Software writes a 4-bit priority code for each queue through a small write port. A weighted code turns into an 8-bit round mask. The block steps through a cycle of eight rounds, and a queue is eligible in a given round only when the mask bit for that round is set. The masks spread their set bits across the cycle, so a queue with a middling weight does not send its packets back to back.

A queue coded as static is served ahead of every weighted queue. Among the static queues, the lowest-numbered non-empty one wins. Static queues are expected to form an unbroken run starting at queue 0, and a flag reports any other arrangement. The block presents one registered grant at a time and keeps it steady until the consumer accepts it. It then uses the next cycle to make a fresh decision.

Top module: `wrr_sched`

## Requirements
- R1: Priority codes 1 to 8 map to the round masks 1→0x01, 2→0x11, 3→0x49, 4→0x55, 5→0x57, 6→0x77, 7→0x7f and 8→0xff, where bit r is round r. When every queue is kept non-empty, one full 8-round cycle starting from reset grants each weighted queue exactly once in every round whose mask bit is set.
- R2: A queue with priority code 0 is never granted.
- R3: Code 9 marks a queue as static. Whenever at least one static queue is non-empty, a new grant goes to the lowest-numbered non-empty static queue, whatever the round.
- R4: Codes 10 to 15 are invalid. Such a queue is scheduled with mask 0xff, and `prio_err` is 1 while any queue holds an invalid code.
- R5: `cfg_err` is 1 exactly when the set of static queues is not a run that starts at queue 0, that is, when some static queue q ≥ 1 has a queue q−1 that is not static.
- R6: Once `grant_valid` is 1, it and `grant_qid` stay unchanged until a cycle with `grant_accept` = 1. After that cycle `grant_valid` is 0 for one cycle.
- R7: Within a round, weighted grants go in ascending queue order from a pointer. After a weighted grant is accepted, the pointer moves to the next queue. Accepting a grant for the last queue, or finding no eligible queue at or after the pointer while some queue is non-empty, moves the block to the next round (modulo 8) with the pointer at 0. While all queues are empty, the round and pointer hold.
- R8: A priority write takes effect for decisions made from the second clock edge after the write cycle, while the port is running.
- R9: An empty queue is never granted.
- R10: After reset, `grant_valid`, `cfg_err` and `prio_err` are 0, every priority is 0, and the block is in round 0 with the pointer at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Priority write strobe |
| cfg_qidx | input | IDX_W | Queue number being written |
| cfg_prio | input | 4 | Priority code (0–8 weighted, 9 static, 10–15 invalid) |
| q_nonempty | input | NUM_Q | One bit per queue, 1 when the queue holds a packet |
| grant_accept | input | 1 | Consumer takes the presented grant |
| grant_valid | output | 1 | A grant is presented |
| grant_qid | output | IDX_W | Granted queue number |
| cfg_err | output | 1 | Static queues do not form a run starting at queue 0 |
| prio_err | output | 1 | Some queue holds an invalid priority code |

## Verification
The case hardest to reach from the ports is the exact interleaving at round boundaries. There, a failed scan costs one cycle and a grant to the last queue wraps the round with no idle cycle. This can only be predicted if the round counter starts from a known place. Because the round and pointer stay still while every queue is empty, the stimulus programs each configuration with the non-empty flags low, then raises them. From that point it predicts the full grant sequence of an 8-round cycle from the masks alone. The sweep covers all sixteen codes across a small four-queue configuration, including broken and intact static runs. Directed cases hold a grant unaccepted while the non-empty flags change, and rewrite a priority in the middle of a run.

// File: rtl/wrr_sched_pkg.sv
package wrr_sched_pkg;
  localparam int PRIO_W      = 4;
  localparam int MASK_W      = 8;
  localparam int STATIC_CODE = 9;
  localparam int MAX_WEIGHT  = 8;

  // Round-enable mask for a weighted code; static and invalid codes open all rounds.
  function automatic logic [MASK_W-1:0] prio_to_mask(input logic [PRIO_W-1:0] code);
    logic [MASK_W-1:0] m;
    case (code)
      4'd0:    m = 8'h00;
      4'd1:    m = 8'h01;
      4'd2:    m = 8'h11;
      4'd3:    m = 8'h49;
      4'd4:    m = 8'h55;
      4'd5:    m = 8'h57;
      4'd6:    m = 8'h77;
      4'd7:    m = 8'h7f;
      default: m = 8'hff;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/wrr_prio_table.sv
module wrr_prio_table
  import wrr_sched_pkg::*;
#(
  parameter int NUM_Q = 8,
  parameter int IDX_W = $clog2(NUM_Q)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [PRIO_W-1:0]             wr_code,
  output logic [NUM_Q-1:0][MASK_W-1:0]  mask_o,
  output logic [NUM_Q-1:0]              static_o,
  output logic                          cfg_err_o,
  output logic                          prio_err_o
);
  logic [PRIO_W-1:0] code_q [NUM_Q];
  logic [NUM_Q-1:0]  bad_code;
  logic [NUM_Q-1:0]  gap;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    always_ff @(posedge clk) begin
      if (rst)
        code_q[q] <= '0;
      else if (wr_en && wr_idx == IDX_W'(q))
        code_q[q] <= wr_code;
    end
    assign mask_o[q]   = prio_to_mask(code_q[q]);
    assign static_o[q] = (code_q[q] == PRIO_W'(STATIC_CODE));
    assign bad_code[q] = (code_q[q] > PRIO_W'(STATIC_CODE));
    if (q == 0) begin : g_base
      assign gap[q] = 1'b0;
    end else begin : g_rest
      assign gap[q] = static_o[q] && !static_o[q-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_err_o  <= 1'b0;
      prio_err_o <= 1'b0;
    end else begin
      cfg_err_o  <= |gap;
      prio_err_o <= |bad_code;
    end
  end
endmodule

// File: rtl/wrr_select.sv
module wrr_select
  import wrr_sched_pkg::*;
#(
  parameter int NUM_Q   = 8,
  parameter int IDX_W   = $clog2(NUM_Q),
  parameter int ROUND_W = $clog2(MASK_W)
) (
  input  logic [NUM_Q-1:0]              nonempty,
  input  logic [NUM_Q-1:0]              is_static,
  input  logic [NUM_Q-1:0][MASK_W-1:0]  masks,
  input  logic [IDX_W-1:0]              ptr,
  input  logic [ROUND_W-1:0]            round,
  output logic                          st_hit,
  output logic [IDX_W-1:0]              st_idx,
  output logic                          w_hit,
  output logic [IDX_W-1:0]              w_idx
);
  always_comb begin
    st_hit = 1'b0;
    st_idx = '0;
    w_hit  = 1'b0;
    w_idx  = '0;
    for (int i = NUM_Q - 1; i >= 0; i--) begin
      if (nonempty[i] && is_static[i]) begin
        st_hit = 1'b1;
        st_idx = IDX_W'(i);
      end
      if (nonempty[i] && masks[i][round] && IDX_W'(i) >= ptr) begin
        w_hit = 1'b1;
        w_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/wrr_sched.sv
module wrr_sched
  import wrr_sched_pkg::*;
#(
  parameter int NUM_Q = 8,
  localparam int IDX_W = $clog2(NUM_Q)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_qidx,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic [NUM_Q-1:0]  q_nonempty,
  input  logic              grant_accept,
  output logic              grant_valid,
  output logic [IDX_W-1:0]  grant_qid,
  output logic              cfg_err,
  output logic              prio_err
);
  localparam int ROUND_W = $clog2(MASK_W);
  localparam logic [IDX_W-1:0] LAST_Q = IDX_W'(NUM_Q - 1);

  logic [NUM_Q-1:0][MASK_W-1:0] mask_vec;
  logic [NUM_Q-1:0]             static_vec;
  logic [IDX_W-1:0]             ptr_q;
  logic [ROUND_W-1:0]           round_q;
  logic                         gstat_q;
  logic                         st_hit, w_hit;
  logic [IDX_W-1:0]             st_idx, w_idx;

  wrr_prio_table #(.NUM_Q(NUM_Q), .IDX_W(IDX_W)) u_table (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (cfg_we),
    .wr_idx    (cfg_qidx),
    .wr_code   (cfg_prio),
    .mask_o    (mask_vec),
    .static_o  (static_vec),
    .cfg_err_o (cfg_err),
    .prio_err_o(prio_err)
  );

  wrr_select #(.NUM_Q(NUM_Q), .IDX_W(IDX_W), .ROUND_W(ROUND_W)) u_select (
    .nonempty (q_nonempty),
    .is_static(static_vec),
    .masks    (mask_vec),
    .ptr      (ptr_q),
    .round    (round_q),
    .st_hit   (st_hit),
    .st_idx   (st_idx),
    .w_hit    (w_hit),
    .w_idx    (w_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid <= 1'b0;
      grant_qid   <= '0;
      gstat_q     <= 1'b0;
      ptr_q       <= '0;
      round_q     <= '0;
    end else if (grant_valid) begin
      if (grant_accept) begin
        grant_valid <= 1'b0;
        if (!gstat_q) begin
          if (grant_qid == LAST_Q) begin
            ptr_q   <= '0;
            round_q <= round_q + 1'b1;
          end else begin
            ptr_q <= grant_qid + 1'b1;
          end
        end
      end
    end else if (st_hit) begin
      grant_valid <= 1'b1;
      grant_qid   <= st_idx;
      gstat_q     <= 1'b1;
    end else if (w_hit) begin
      grant_valid <= 1'b1;
      grant_qid   <= w_idx;
      gstat_q     <= 1'b0;
    end else if (|q_nonempty) begin
      ptr_q   <= '0;
      round_q <= round_q + 1'b1;
    end
  end
endmodule

// File: rtl/wrr_sched_checker.sv
module wrr_sched_checker #(
  parameter int NUM_Q = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             grant_valid,
  input logic             grant_accept,
  input logic [IDX_W-1:0] grant_qid,
  input logic [NUM_Q-1:0] q_nonempty,
  input logic [NUM_Q-1:0] is_static,
  input logic             cfg_err
);
  logic [NUM_Q-1:0] prev_ne, prev_st, below;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_ne <= '0;
      prev_st <= '0;
    end else begin
      prev_ne <= q_nonempty;
      prev_st <= is_static;
    end
  end

  assign below = (NUM_Q'(1) << grant_qid) - NUM_Q'(1);

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    grant_valid && !grant_accept |=> grant_valid && $stable(grant_qid));

  assert_release_R6: assert property (@(posedge clk) disable iff (rst)
    grant_valid && grant_accept |=> !grant_valid);

  assert_nonempty_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_valid) |-> prev_ne[grant_qid]);

  assert_static_first_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_valid) && (|(prev_st & prev_ne)) |->
      prev_st[grant_qid] && ((prev_st & prev_ne & below) == '0));

  assert_cfg_err_R5: assert property (@(posedge clk) disable iff (rst)
    !is_static[0] && (|is_static) |=> cfg_err);
endmodule

bind wrr_sched wrr_sched_checker #(.NUM_Q(NUM_Q), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .grant_valid (grant_valid),
  .grant_accept(grant_accept),
  .grant_qid   (grant_qid),
  .q_nonempty  (q_nonempty),
  .is_static   (static_vec),
  .cfg_err     (cfg_err)
);

// File: tb/wrr_sched_bench.sv
module wrr_sched_bench;
  localparam int NQ = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_qidx = '0;
  logic [3:0] cfg_prio = '0;
  logic [NQ-1:0] q_nonempty = '0;
  logic       grant_accept = 1'b0;
  logic       grant_valid;
  logic [1:0] grant_qid;
  logic       cfg_err, prio_err;

  int nvec = 0;
  int nfail = 0;
  int cyc = 0;

  wrr_sched #(.NUM_Q(NQ)) u_wrr_sched (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_qidx(cfg_qidx), .cfg_prio(cfg_prio),
    .q_nonempty(q_nonempty), .grant_accept(grant_accept), .grant_valid(grant_valid),
    .grant_qid(grant_qid), .cfg_err(cfg_err), .prio_err(prio_err)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  function automatic int spec_mask(int p);
    case (p)
      0: return 'h00; 1: return 'h01; 2: return 'h11; 3: return 'h49;
      4: return 'h55; 5: return 'h57; 6: return 'h77; 7: return 'h7f;
      default: return 'hff;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; q_nonempty = '0; grant_accept = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(int q, int p);
    @(negedge clk); cfg_we = 1'b1; cfg_qidx = 2'(q); cfg_prio = 4'(p);
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // Waits for a grant, returns its queue (-1 on timeout) and accepts it.
  task automatic take(output int got);
    int w = 0;
    while (!grant_valid && w < 40) begin @(negedge clk); w++; end
    if (!grant_valid) got = -1;
    else begin
      got = int'(grant_qid);
      grant_accept = 1'b1;
      @(negedge clk);
      grant_accept = 1'b0;
    end
  endtask

  initial begin
    int got;
    int prio [NQ];
    int ne, lowst, n, exp_cfg, exp_perr, hits;
    int seq [64];

    // R10: reset state
    do_reset();
    @(negedge clk);
    chk(grant_valid == 1'b0, "R10 grant_valid after reset", int'(grant_valid), 0);
    chk(cfg_err == 1'b0, "R10 cfg_err after reset", int'(cfg_err), 0);
    chk(prio_err == 1'b0, "R10 prio_err after reset", int'(prio_err), 0);
    q_nonempty = 4'hF;
    hits = 0;
    for (int k = 0; k < 30; k++) begin @(negedge clk); if (grant_valid) hits++; end
    chk(hits == 0, "R10 R2 all codes 0 after reset give no grant", hits, 0);

    // Sweep: R1 R2 R3 R4 R5 R7 R9
    for (int c = 0; c < 48; c++) begin
      do_reset();
      for (int q = 0; q < NQ; q++) prio[q] = (c * 7 + q * 5 + c / 16) % 16;
      if (c % 4 == 0) prio[0] = 9;
      if (c % 8 == 0) prio[1] = 9;
      if (c % 6 == 1) prio[2] = 9;
      ne = (c % 3 == 0) ? 15 : (c * 11 + 3) % 16;
      for (int q = 0; q < NQ; q++) wr(q, prio[q]);
      repeat (3) @(negedge clk);
      exp_cfg = 0; exp_perr = 0;
      for (int q = 0; q < NQ; q++) begin
        if (prio[q] > 9) exp_perr = 1;
        if (q > 0 && prio[q] == 9 && prio[q-1] != 9) exp_cfg = 1;
      end
      chk(int'(cfg_err) == exp_cfg, "R5 cfg_err", int'(cfg_err), exp_cfg);
      chk(int'(prio_err) == exp_perr, "R4 prio_err", int'(prio_err), exp_perr);
      lowst = -1;
      for (int q = NQ - 1; q >= 0; q--) if (prio[q] == 9 && ne[q]) lowst = q;
      q_nonempty = 4'(ne);
      if (lowst >= 0) begin
        for (int k = 0; k < 5; k++) begin
          take(got);
          chk(got == lowst, "R3 lowest non-empty static queue", got, lowst);
        end
      end else begin
        n = 0;
        for (int r = 0; r < 8; r++)
          for (int q = 0; q < NQ; q++)
            if (ne[q] && ((spec_mask(prio[q]) >> r) & 1) == 1) begin seq[n] = q; n++; end
        if (n == 0) begin
          hits = 0;
          for (int k = 0; k < 30; k++) begin @(negedge clk); if (grant_valid) hits++; end
          chk(hits == 0, "R2 R9 no eligible queue gives no grant", hits, 0);
        end else begin
          for (int k = 0; k < n; k++) begin
            take(got);
            chk(got == seq[k], "R1 R4 R7 R9 weighted round order", got, seq[k]);
          end
        end
      end
    end

    // R6: grant held until accepted
    do_reset();
    wr(0, 9); wr(1, 9);
    q_nonempty = 4'b0010;
    while (!grant_valid) @(negedge clk);
    q_nonempty = 4'b0001;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(grant_valid && grant_qid == 2'd1, "R6 grant held without accept", int'(grant_qid), 1);
    end
    grant_accept = 1'b1; @(negedge clk); grant_accept = 1'b0;
    chk(grant_valid == 1'b0, "R6 grant dropped after accept", int'(grant_valid), 0);
    take(got);
    chk(got == 0, "R3 R6 next decision serves queue 0", got, 0);

    // R8: priority change while running
    do_reset();
    for (int q = 0; q < NQ; q++) wr(q, 8);
    q_nonempty = 4'hF;
    hits = 0;
    for (int k = 0; k < 3; k++) begin take(got); if (got == 2) hits++; end
    chk(hits == 1, "R8 queue 2 served before rewrite", hits, 1);
    wr(2, 0);
    take(got); take(got);
    hits = 0;
    for (int k = 0; k < 24; k++) begin take(got); if (got == 2 || got < 0) hits++; end
    chk(hits == 0, "R8 R2 rewritten queue 2 no longer served", hits, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule